// File: doc/BRIEF.md
# Processor Register Window with Live Special Registers

This block is the register file of a small processor core: 512 words of 32 bits, read through two independent ports (a destination-operand port and a source-operand port) and written through one normal write port plus a dedicated link-write input. The top sixteen addresses form a window onto live hardware state. Four of them return live inputs: a free-running timer, a random source and two 32-bit input-pin ports. Eight are shadowed control registers: pin output and direction for two ports, and the control and frequency words of two counters. A write updates both the RAM cell and the live register, and a read returns the RAM copy. The last four are direct registers (two counter phases and two pointers) with no RAM copy behind them.

The link input serves jump-with-link and location-load operations. Both deposit their value in the word just below the window. Reads are combinational from the address. Writes take effect at the rising clock edge, so a value written in one cycle can be read in the next.

Top module: `regwin_top`

## Requirements
- R1: Addresses 0x000 to 0x1EF behave as plain RAM. A word written at one edge is returned on either read port in the following cycles, and both ports may read different addresses in the same cycle.
- R2: A read of 0x1F0, 0x1F1, 0x1F2 or 0x1F3 returns, in the same cycle, the timer input, the random input, pin input A or pin input B respectively.
- R3: A write to 0x1F0 to 0x1F3 has no visible effect. Later reads of that address still return the live input, and no live output changes.
- R4: A write to 0x1F4 to 0x1FB updates, after the edge, the matching live output (in address order: pin output A, pin output B, pin direction A, pin direction B, counter control A, counter control B, counter frequency A, counter frequency B). A later read of the address returns the same value from the RAM copy, so a read-modify-write sees the last value written.
- R5: A write to 0x1FC to 0x1FF (counter phase A, counter phase B, pointer A, pointer B) updates that live register after the edge, and a read of the address returns the live register.
- R6: The pointer registers keep 19 bits. Bits 31:19 of both the pointer outputs and their reads are always zero.
- R7: A link write stores a value at 0x1EF. For a jump link (link_loc=0) the value is {13'b0, Z, C, PC[16:0]}, with Z at bit 18 and C at bit 17. For a location load (link_loc=1) the value is the 17-bit address, zero-extended.
- R8: When the normal write port and the link write both target 0x1EF in one cycle, the link value is stored. A normal write to any other address in the same cycle as a link write still takes effect.
- R9: A synchronous active-low reset clears all twelve live registers to zero by the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_dst_addr | input | 9 | Destination-operand read address |
| rd_dst_data | output | 32 | Destination-operand read data |
| rd_src_addr | input | 9 | Source-operand read address |
| rd_src_data | output | 32 | Source-operand read data |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 9 | Normal write address |
| wr_data | input | 32 | Normal write data |
| link_en | input | 1 | Link write enable (targets 0x1EF) |
| link_loc | input | 1 | 0: jump link with flags, 1: location load |
| link_z | input | 1 | Zero flag for a jump link |
| link_c | input | 1 | Carry flag for a jump link |
| link_pc | input | 17 | Program counter or loaded address |
| timer_in | input | 32 | Live free-running timer |
| rand_in | input | 32 | Live random value |
| pin_in_a | input | 32 | Live pin input port A |
| pin_in_b | input | 32 | Live pin input port B |
| pin_out_a | output | 32 | Pin output register A |
| pin_out_b | output | 32 | Pin output register B |
| pin_dir_a | output | 32 | Pin direction register A |
| pin_dir_b | output | 32 | Pin direction register B |
| ctrl_a | output | 32 | Counter control A |
| ctrl_b | output | 32 | Counter control B |
| freq_a | output | 32 | Counter frequency A |
| freq_b | output | 32 | Counter frequency B |
| phase_a | output | 32 | Counter phase A |
| phase_b | output | 32 | Counter phase B |
| ptr_a | output | 32 | Pointer A (19 significant bits) |
| ptr_b | output | 32 | Pointer B (19 significant bits) |

## Verification
The assertions assume that the inputs are known (no X) whenever reset is released. They also assume that only this block's own write ports change the live registers, so an output that holds its value after a write to a live-input address means the write was ignored. The link-priority property assumes that the destination read port shows the RAM word at 0x1EF one cycle after a link write. The bench drives every input from negative clock edges with fixed known values, holds the read address of that port for the checking cycle, and never reads a RAM word it has not written.

// File: rtl/regwin_pkg.sv
// Shared types for the register window: address regions and window layout.
// Assumes the window occupies the top sixteen addresses of the register file.
package regwin_pkg;

    typedef enum logic [1:0] {
        RG_RAM     = 2'd0,
        RG_SHADOW  = 2'd1,
        RG_LIVE_IN = 2'd2,
        RG_DIRECT  = 2'd3
    } region_e;

    localparam int WIN_N      = 16;
    localparam int LIVE_IN_N  = 4;
    localparam int SHADOW_N   = 8;
    localparam int DIRECT_N   = 4;
    localparam int PTR_N      = 2;
    localparam int LIVE_REG_N = SHADOW_N + DIRECT_N;

endpackage

// File: rtl/regwin_decode.sv
// Address classifier: maps a register-file address onto its region and its
// slot within the top window. Assumes ADDR_W > 4.
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [3:0]        slot
);

    localparam logic [ADDR_W-5:0] WIN_TAG = '1;

    // Classify the address by its window tag and slot number.
    always_comb begin
        slot = addr[3:0];
        if (addr[ADDR_W-1:4] != WIN_TAG) begin
            region = RG_RAM;
        end else if (int'(addr[3:0]) < LIVE_IN_N) begin
            region = RG_LIVE_IN;
        end else if (int'(addr[3:0]) < LIVE_IN_N + SHADOW_N) begin
            region = RG_SHADOW;
        end else begin
            region = RG_DIRECT;
        end
    end

endmodule

// File: rtl/regwin_ram.sv
// Backing storage: asynchronous read ports and two write ports, where the
// second (link) port overrides the first when both hit the same word.
// Contents are not reset.
module regwin_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9,
    parameter int RD_N   = 2
) (
    input  logic                         clk,
    input  logic [RD_N-1:0][ADDR_W-1:0]  rd_addr,
    output logic [RD_N-1:0][DATA_W-1:0]  rd_data,
    input  logic                         we0,
    input  logic [ADDR_W-1:0]            wa0,
    input  logic [DATA_W-1:0]            wd0,
    input  logic                         we1,
    input  logic [ADDR_W-1:0]            wa1,
    input  logic [DATA_W-1:0]            wd1
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store writes; the later statement gives the link port priority.
    always_ff @(posedge clk) begin
        if (we0) begin
            mem[wa0] <= wd0;
        end
        if (we1) begin
            mem[wa1] <= wd1;
        end
    end

    for (genvar p = 0; p < RD_N; p++) begin : g_rd
        // Combinational read of one port.
        assign rd_data[p] = mem[rd_addr[p]];
    end

endmodule

// File: rtl/regwin_live.sv
// Bank of live hardware registers behind the window (shadowed and direct).
// The last PTR_N entries keep only PTR_W bits and read zero above them.
// Synchronous active-low reset clears every entry.
module regwin_live #(
    parameter int DATA_W = 32,
    parameter int PTR_W  = 19,
    parameter int N      = 12,
    parameter int PTR_N  = 2,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [N-1:0][DATA_W-1:0]  q
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam int KEEP = (i >= N - PTR_N) ? PTR_W : DATA_W;
        logic [KEEP-1:0] r;

        // Load this entry when the steered write selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                r <= wr_data[KEEP-1:0];
            end
        end

        if (KEEP < DATA_W) begin : g_narrow
            assign q[i] = {{(DATA_W-KEEP){1'b0}}, r};
        end else begin : g_full
            assign q[i] = r;
        end
    end

endmodule

// File: rtl/regwin_top.sv
// Register window top: 2^ADDR_W-word register file whose top sixteen words
// map onto live inputs, shadowed control registers and direct registers.
// Reads are combinational; writes land at the rising edge. A link write
// always targets the word just below the window and wins over a normal
// write to that word.
module regwin_top
    import regwin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9,
    parameter int PC_W   = 17,
    parameter int PTR_W  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_dst_addr,
    output logic [DATA_W-1:0] rd_dst_data,
    input  logic [ADDR_W-1:0] rd_src_addr,
    output logic [DATA_W-1:0] rd_src_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic              link_loc,
    input  logic              link_z,
    input  logic              link_c,
    input  logic [PC_W-1:0]   link_pc,
    input  logic [DATA_W-1:0] timer_in,
    input  logic [DATA_W-1:0] rand_in,
    input  logic [DATA_W-1:0] pin_in_a,
    input  logic [DATA_W-1:0] pin_in_b,
    output logic [DATA_W-1:0] pin_out_a,
    output logic [DATA_W-1:0] pin_out_b,
    output logic [DATA_W-1:0] pin_dir_a,
    output logic [DATA_W-1:0] pin_dir_b,
    output logic [DATA_W-1:0] ctrl_a,
    output logic [DATA_W-1:0] ctrl_b,
    output logic [DATA_W-1:0] freq_a,
    output logic [DATA_W-1:0] freq_b,
    output logic [DATA_W-1:0] phase_a,
    output logic [DATA_W-1:0] phase_b,
    output logic [DATA_W-1:0] ptr_a,
    output logic [DATA_W-1:0] ptr_b
);

    localparam int RD_N  = 2;
    localparam int IDX_W = $clog2(LIVE_REG_N);
    localparam logic [ADDR_W-1:0] WIN_BASE  = ADDR_W'((1 << ADDR_W) - WIN_N);
    localparam logic [ADDR_W-1:0] LINK_ADDR = WIN_BASE - ADDR_W'(1);

    logic [RD_N-1:0][ADDR_W-1:0]       rd_addr;
    logic [RD_N-1:0][DATA_W-1:0]       ram_rd;
    logic [RD_N-1:0][DATA_W-1:0]       rd_data;
    logic [LIVE_IN_N-1:0][DATA_W-1:0]  live_in;
    logic [LIVE_REG_N-1:0][DATA_W-1:0] live_q;
    region_e                           wr_region;
    logic [3:0]                        wr_slot;
    logic                              ram_we;
    logic                              live_we;
    logic [IDX_W-1:0]                  live_idx;
    logic [DATA_W-1:0]                 link_val;

    assign rd_addr     = {rd_src_addr, rd_dst_addr};
    assign rd_dst_data = rd_data[0];
    assign rd_src_data = rd_data[1];
    assign live_in     = {pin_in_b, pin_in_a, rand_in, timer_in};

    // Format the link word: flags above the address, or the bare address.
    assign link_val = link_loc ? DATA_W'(link_pc)
                               : DATA_W'({link_z, link_c, link_pc});

    regwin_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
        .addr   (wr_addr),
        .region (wr_region),
        .slot   (wr_slot)
    );

    // Steer the normal write to RAM and/or the live bank by region.
    always_comb begin
        ram_we   = wr_en && (wr_region == RG_RAM || wr_region == RG_SHADOW)
                   && !(link_en && wr_addr == LINK_ADDR);
        live_we  = wr_en && (wr_region == RG_SHADOW || wr_region == RG_DIRECT);
        live_idx = IDX_W'(wr_slot - 4'(LIVE_IN_N));
    end

    regwin_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_N(RD_N)) u_ram (
        .clk     (clk),
        .rd_addr (rd_addr),
        .rd_data (ram_rd),
        .we0     (ram_we),
        .wa0     (wr_addr),
        .wd0     (wr_data),
        .we1     (link_en),
        .wa1     (LINK_ADDR),
        .wd1     (link_val)
    );

    regwin_live #(
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W),
        .N      (LIVE_REG_N),
        .PTR_N  (PTR_N)
    ) u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (live_we),
        .wr_idx  (live_idx),
        .wr_data (wr_data),
        .q       (live_q)
    );

    for (genvar p = 0; p < RD_N; p++) begin : g_port
        region_e    rg;
        logic [3:0] sl;
        logic [3:0] dix;

        regwin_decode #(.ADDR_W(ADDR_W)) u_dec (
            .addr   (rd_addr[p]),
            .region (rg),
            .slot   (sl)
        );

        assign dix = sl - 4'(LIVE_IN_N);

        // Select the read source for this port by region.
        always_comb begin
            case (rg)
                RG_LIVE_IN: rd_data[p] = live_in[sl[1:0]];
                RG_DIRECT:  rd_data[p] = live_q[dix[IDX_W-1:0]];
                default:    rd_data[p] = ram_rd[p];
            endcase
        end
    end

    assign pin_out_a = live_q[0];
    assign pin_out_b = live_q[1];
    assign pin_dir_a = live_q[2];
    assign pin_dir_b = live_q[3];
    assign ctrl_a    = live_q[4];
    assign ctrl_b    = live_q[5];
    assign freq_a    = live_q[6];
    assign freq_b    = live_q[7];
    assign phase_a   = live_q[8];
    assign phase_b   = live_q[9];
    assign ptr_a     = live_q[10];
    assign ptr_b     = live_q[11];

endmodule

// File: rtl/regwin_checker.sv
// Temporal checks on the register window, bound to every regwin_top.
// Assumes the default widths and inputs that are known after reset.
module regwin_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9,
    parameter int PC_W   = 17,
    parameter int PTR_W  = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_en,
    input logic              link_loc,
    input logic              link_z,
    input logic              link_c,
    input logic [PC_W-1:0]   link_pc,
    input logic [ADDR_W-1:0] rd_dst_addr,
    input logic [DATA_W-1:0] rd_dst_data,
    input logic [DATA_W-1:0] timer_in,
    input logic [DATA_W-1:0] pin_out_a,
    input logic [DATA_W-1:0] pin_out_b,
    input logic [DATA_W-1:0] pin_dir_a,
    input logic [DATA_W-1:0] pin_dir_b,
    input logic [DATA_W-1:0] ctrl_a,
    input logic [DATA_W-1:0] ctrl_b,
    input logic [DATA_W-1:0] freq_a,
    input logic [DATA_W-1:0] freq_b,
    input logic [DATA_W-1:0] phase_a,
    input logic [DATA_W-1:0] phase_b,
    input logic [DATA_W-1:0] ptr_a,
    input logic [DATA_W-1:0] ptr_b
);

    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'((1 << ADDR_W) - 16);
    localparam logic [ADDR_W-1:0] A_LINK   = WIN_BASE - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_OUT_A  = WIN_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_FRQ_B  = WIN_BASE + ADDR_W'(11);
    localparam logic [ADDR_W-1:0] A_PHS_B  = WIN_BASE + ADDR_W'(13);

    logic [DATA_W*12-1:0] all_live;
    logic [DATA_W-1:0]    exp_link;
    logic                 was_rst;

    assign all_live = {pin_out_a, pin_out_b, pin_dir_a, pin_dir_b, ctrl_a, ctrl_b,
                       freq_a, freq_b, phase_a, phase_b, ptr_a, ptr_b};
    assign exp_link = link_loc ? DATA_W'(link_pc) : DATA_W'({link_z, link_c, link_pc});

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    AST_LIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dst_addr == WIN_BASE) |-> (rd_dst_data == timer_in)); // R2

    AST_LIVE_IN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1:2] == WIN_BASE[ADDR_W-1:2]) |=> $stable(all_live)); // R3

    AST_SHADOW_OUT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_OUT_A) |=> (pin_out_a == $past(wr_data))); // R4

    AST_SHADOW_FRQ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FRQ_B) |=> (freq_b == $past(wr_data))); // R4

    AST_DIRECT_PHS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PHS_B) |=> (phase_b == $past(wr_data))); // R5

    AST_PTR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_a[DATA_W-1:PTR_W] == '0) && (ptr_b[DATA_W-1:PTR_W] == '0)); // R6

    AST_LINK_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> (rd_dst_addr != A_LINK || rd_dst_data == $past(exp_link))); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (all_live == '0)); // R9

endmodule

bind regwin_top regwin_checker u_chk (.*);

// File: tb/regwin_top_test.sv
// Scoreboard bench for regwin_top: driver tasks queue expected items with
// the cycle they are due; a monitor pops and compares them at mid-cycle.
module regwin_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  rd_dst_addr = '0;
    logic [31:0] rd_dst_data;
    logic [8:0]  rd_src_addr = '0;
    logic [31:0] rd_src_data;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        link_en = 1'b0;
    logic        link_loc = 1'b0;
    logic        link_z = 1'b0;
    logic        link_c = 1'b0;
    logic [16:0] link_pc = '0;
    logic [31:0] timer_in = 32'h1111_0001;
    logic [31:0] rand_in  = 32'h2222_0002;
    logic [31:0] pin_in_a = 32'h3333_0003;
    logic [31:0] pin_in_b = 32'h4444_0004;
    logic [31:0] pin_out_a, pin_out_b, pin_dir_a, pin_dir_b;
    logic [31:0] ctrl_a, ctrl_b, freq_a, freq_b;
    logic [31:0] phase_a, phase_b, ptr_a, ptr_b;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    regwin_top uut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // kind 0: destination read, 1: source read, 2..13: live outputs in address order
    function automatic logic [31:0] observe(int kind);
        case (kind)
            0:  return rd_dst_data;
            1:  return rd_src_data;
            2:  return pin_out_a;
            3:  return pin_out_b;
            4:  return pin_dir_a;
            5:  return pin_dir_b;
            6:  return ctrl_a;
            7:  return ctrl_b;
            8:  return freq_a;
            9:  return freq_b;
            10: return phase_a;
            11: return phase_b;
            12: return ptr_a;
            default: return ptr_b;
        endcase
    endfunction

    task automatic expect_item(int kind, int delay, logic [31:0] exp, string tag);
        item_t it;
        it.due  = cyc + delay;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic write_word(logic [8:0] a, logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_dst(logic [8:0] a, logic [31:0] exp, string tag);
        rd_dst_addr = a;
        expect_item(0, 0, exp, tag);
        @(negedge clk);
    endtask

    task automatic read_both(logic [8:0] a, logic [31:0] ea, logic [8:0] b,
                             logic [31:0] eb, string tag);
        rd_dst_addr = a;
        rd_src_addr = b;
        expect_item(0, 0, ea, tag);
        expect_item(1, 0, eb, tag);
        @(negedge clk);
    endtask

    task automatic expect_all_live_zero(string tag);
        for (int k = 2; k < 14; k++) expect_item(k, 0, 32'h0, tag);
    endtask

    // Monitor: compare due items in the middle of the low phase.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                got = observe(it.kind);
                checks++;
                if (got !== it.exp) begin
                    failures++;
                    $display("FAIL %s kind=%0d actual=%08h expected=%08h",
                             it.tag, it.kind, got, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        expect_all_live_zero("R9 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: plain RAM, both ports
        write_word(9'h000, 32'hA5A5_0000);
        write_word(9'h0AB, 32'h1234_5678);
        write_word(9'h1EE, 32'hCAFE_F00D);
        write_word(9'h1EF, 32'h0BAD_BEEF);
        read_both(9'h000, 32'hA5A5_0000, 9'h0AB, 32'h1234_5678, "R1 ram pair");
        read_both(9'h1EF, 32'h0BAD_BEEF, 9'h1EE, 32'hCAFE_F00D, "R1 ram top");

        // R2: live inputs on both ports
        read_both(9'h1F0, 32'h1111_0001, 9'h1F1, 32'h2222_0002, "R2 timer/rand");
        read_both(9'h1F2, 32'h3333_0003, 9'h1F3, 32'h4444_0004, "R2 pins");
        timer_in = 32'h7777_AAAA;
        read_dst(9'h1F0, 32'h7777_AAAA, "R2 timer follows input");

        // R4: shadowed registers, output after the edge and RAM readback
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            v = 32'h5000_0000 + 32'(i * 32'h0101_0101);
            expect_item(2 + i, 1, v, "R4 live output");
            write_word(9'h1F4 + 9'(i), v);
            read_dst(9'h1F4 + 9'(i), v, "R4 ram copy read");
        end
        // R4: read-modify-write on pin direction A sees the last value written
        write_word(9'h1F6, 32'h0000_00F0);
        read_dst(9'h1F6, 32'h0000_00F0, "R4 rmw read");
        expect_item(4, 1, 32'h0000_00FF, "R4 rmw result");
        write_word(9'h1F6, 32'h0000_00F0 | 32'h0000_000F);
        read_src_check: begin
            rd_src_addr = 9'h1F6;
            expect_item(1, 0, 32'h0000_00FF, "R4 rmw readback");
            @(negedge clk);
        end

        // R3: writes to live-input addresses are ignored
        write_word(9'h1F2, 32'hDEAD_0000);
        write_word(9'h1F0, 32'hDEAD_0001);
        read_dst(9'h1F2, 32'h3333_0003, "R3 read stays live");
        expect_item(2, 0, 32'h5000_0000, "R3 pin out A unchanged");
        expect_item(12, 0, 32'h0, "R3 ptr A unchanged");
        pin_in_a = 32'h9999_1234;
        read_dst(9'h1F2, 32'h9999_1234, "R3 read follows new input");

        // R5: direct registers
        expect_item(10, 1, 32'h0F0F_1234, "R5 phase A");
        write_word(9'h1FC, 32'h0F0F_1234);
        expect_item(11, 1, 32'hF0F0_4321, "R5 phase B");
        write_word(9'h1FD, 32'hF0F0_4321);
        read_both(9'h1FC, 32'h0F0F_1234, 9'h1FD, 32'hF0F0_4321, "R5 phase reads");

        // R6: pointers keep 19 bits
        expect_item(12, 1, 32'h0007_FFFF, "R6 ptr A masked");
        write_word(9'h1FE, 32'hFFFF_FFFF);
        expect_item(13, 1, 32'h0002_3456, "R6 ptr B masked");
        write_word(9'h1FF, 32'hABC2_3456);
        read_both(9'h1FE, 32'h0007_FFFF, 9'h1FF, 32'h0002_3456, "R6 ptr reads");

        // R7: jump link {Z,C,PC}: Z=1,C=0,PC=1ABCD -> 0005ABCD
        link_en = 1'b1; link_loc = 1'b0; link_z = 1'b1; link_c = 1'b0; link_pc = 17'h1ABCD;
        @(negedge clk);
        link_en = 1'b0;
        read_dst(9'h1EF, 32'h0005_ABCD, "R7 jump link");
        // R7: Z=0,C=1,PC=00042 -> 00020042
        link_en = 1'b1; link_z = 1'b0; link_c = 1'b1; link_pc = 17'h00042;
        @(negedge clk);
        link_en = 1'b0;
        read_dst(9'h1EF, 32'h0002_0042, "R7 carry bit");
        // R7: location load, flags ignored
        link_en = 1'b1; link_loc = 1'b1; link_z = 1'b1; link_c = 1'b1; link_pc = 17'h12345;
        @(negedge clk);
        link_en = 1'b0;
        read_dst(9'h1EF, 32'h0001_2345, "R7 location load");

        // R8: link wins over a normal write to the same word
        link_en = 1'b1; link_loc = 1'b1; link_pc = 17'h0ABCD;
        write_word(9'h1EF, 32'hDEAD_BEEF);
        link_en = 1'b0;
        read_dst(9'h1EF, 32'h0000_ABCD, "R8 link wins");
        // R8: normal write elsewhere in the same cycle still lands
        link_en = 1'b1; link_loc = 1'b0; link_z = 1'b0; link_c = 1'b0; link_pc = 17'h00077;
        write_word(9'h010, 32'h6666_7777);
        link_en = 1'b0;
        read_both(9'h1EF, 32'h0000_0077, 9'h010, 32'h6666_7777, "R8 both land");

        // R9: reset clears the live registers again
        rst_n = 1'b0;
        @(negedge clk);
        expect_all_live_zero("R9 reset clears");
        @(negedge clk);
        rst_n = 1'b1;
        read_dst(9'h1FC, 32'h0, "R9 phase read after reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule